// File: doc/BRIEF.md
# Boot Control-Block Loader

This block is the start-up sequencer of a processor. It leaves reset on its own, or it starts when software asks for a reinitialization and supplies the address of a boot control block. It then reads a fixed series of words from memory through a read port that allows one request at a time. From those words it derives the architectural configuration registers and presents them as outputs:

- the fault, control, interrupt and system-procedure table bases
- the arithmetic-control and fault-configuration words and the alignment-fault policy
- the supervisor, interrupt, frame, stack and previous-frame pointers
- the instruction-cache control and the register-cache limit

During the sequence it also zeroes the debug breakpoint state, the timer mode fields, the data-cache enable and the local-memory-region enables. Two of the reads are indirect. One reads the non-maskable-interrupt vector out of the interrupt table and copies it into local data RAM word 0. The other reads the supervisor stack word out of the system-procedure table.

The loader holds `busy` high while it works and pulses `done` for one cycle at the end. It uses the same sequence for the power-on run, which takes the pointer from a parameter, and for every software-requested run, which takes the pointer from `start_ptr`.

Top module: `boot_blk_loader`

## Requirements
- R1: Exactly eleven reads are issued, in this order. With P the latched control-block pointer, the addresses are P+0x00, P+0x04, P+0x08, P+0x0C, P+0x10, then IT+0x3E4 (where IT is the word read from P+0x10), then P+0x14, then SPT+0x0C (where SPT is the word read from P+0x14), then P+0x1C, P+0x20 and P+0x24.
- R2: When the sequence ends, the four table-base outputs hold their words unchanged: fault table from P+0x00, control table from P+0x04, interrupt table from P+0x10 and system-procedure table from P+0x14. So do the arithmetic-control word from P+0x08 and the fault-configuration word from P+0x0C.
- R3: `unaligned_fault_en` is 0 when bit 30 of the fault-configuration word is 1, and it is 1 when that bit is 0.
- R4: The word read from IT+0x3E4 is written once to local RAM address 0, with a single-cycle `ram_we`.
- R5: `sup_stack_ptr` is the word from SPT+0x0C with bits 1:0 cleared, and `trace_en` is bit 0 of that word.
- R6: `intr_stack_ptr` is the word from P+0x1C. `frame_ptr` and `prev_frame_ptr` are that word with bits 3:0 cleared. `stack_ptr` is `frame_ptr` + 64.
- R7: `icache_ctl` is the word from P+0x20, and `icache_dis` equals bit 16 of that word.
- R8: `regcache_limit` equals bits 10:8 of the word at P+0x24.
- R9: At the end of every sequence, the two instruction-breakpoint registers, the two data-breakpoint registers, the breakpoint control, both 6-bit timer mode fields, `dcache_en`, `lmr0_en` and `lmr1_en` are all zero.
- R10: `rd_req` is a one-cycle pulse. No new request is made until `rd_valid` has returned data for the previous one.
- R11: After reset the sequence runs without any request, using the parameter `BOOT_PTR`. A `start` pulse while idle runs the sequence again with `start_ptr`.
- R12: `busy` is high from reset or an accepted start until `done`. `done` is high for exactly one cycle, and `busy` is low in the cycle after it. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | reinitialization request |
| start_ptr | input | 32 | control-block address for a reinitialization |
| rd_req | output | 1 | read request pulse |
| rd_addr | output | 32 | read address, valid with rd_req |
| rd_valid | input | 1 | read data valid |
| rd_data | input | 32 | read data |
| ram_we | output | 1 | local RAM write strobe |
| ram_addr | output | RAM_AW | local RAM write address |
| ram_wdata | output | 32 | local RAM write data |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle end-of-sequence pulse |
| fault_tbl_base | output | 32 | fault table base |
| ctrl_tbl_base | output | 32 | control table base |
| arith_ctl | output | 32 | arithmetic-control word |
| fault_cfg | output | 32 | fault-configuration word |
| unaligned_fault_en | output | 1 | fault on unaligned access |
| intr_tbl_base | output | 32 | interrupt table base |
| sysproc_base | output | 32 | system-procedure table base |
| sup_stack_ptr | output | 32 | supervisor stack pointer |
| trace_en | output | 1 | supervisor trace enable |
| intr_stack_ptr | output | 32 | interrupt stack pointer |
| frame_ptr | output | 32 | frame pointer |
| stack_ptr | output | 32 | stack pointer |
| prev_frame_ptr | output | 32 | previous frame pointer |
| icache_ctl | output | 32 | instruction-cache control word |
| icache_dis | output | 1 | instruction-cache disable |
| regcache_limit | output | 3 | register-cache limit |
| ibrk0 | output | 32 | instruction breakpoint 0 |
| ibrk1 | output | 32 | instruction breakpoint 1 |
| dbrk0 | output | 32 | data breakpoint 0 |
| dbrk1 | output | 32 | data breakpoint 1 |
| brk_ctl | output | 32 | breakpoint control |
| tmr0_mode | output | 6 | timer 0 mode fields |
| tmr1_mode | output | 6 | timer 1 mode fields |
| dcache_en | output | 1 | data-cache enable |
| lmr0_en | output | 1 | local-memory-region 0 enable |
| lmr1_en | output | 1 | local-memory-region 1 enable |

## Verification
The bench targets the two indirect reads. If the loader took the table base before that word had arrived, or used the wrong offset, the scoreboard would see a read address different from the one it expects. It also uses control-block words that make the derived fields fall on edges:

- a fault-configuration word with only bit 30 set, which catches a policy bit that is inverted or taken from the wrong position;
- a stack word with both low bits set, which catches a mask that clears the wrong bits;
- an interrupt stack address with all low four bits set, which catches an error in the frame alignment or the 64-byte offset;
- a limit word whose neighbouring bits are all ones, which catches a field that is shifted.

It varies the read latency, and it pulses `start` in the middle of a run. A loader that accepted that pulse would issue reads from the new block, and the scoreboard would report them as unexpected.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NMI_SLOT = 248;
  localparam logic [WORD_W-1:0] NMI_OFS = WORD_W'(NMI_SLOT * 4 + 4);

  typedef enum logic [3:0] {
    ST_FT, ST_CT, ST_AC, ST_FC, ST_IT, ST_NMI,
    ST_SPT, ST_SSP, ST_ISP, ST_ICC, ST_RCL
  } step_e;

  typedef enum logic [2:0] {
    PH_LAUNCH, PH_IDLE, PH_ISSUE, PH_WAIT, PH_FINISH
  } phase_e;

  function automatic logic [WORD_W-1:0] step_addr(
    step_e s, logic [WORD_W-1:0] p, logic [WORD_W-1:0] it, logic [WORD_W-1:0] spt);
    case (s)
      ST_FT:   return p;
      ST_CT:   return p + 32'h04;
      ST_AC:   return p + 32'h08;
      ST_FC:   return p + 32'h0C;
      ST_IT:   return p + 32'h10;
      ST_NMI:  return it + NMI_OFS;
      ST_SPT:  return p + 32'h14;
      ST_SSP:  return spt + 32'h0C;
      ST_ISP:  return p + 32'h1C;
      ST_ICC:  return p + 32'h20;
      default: return p + 32'h24;
    endcase
  endfunction

  function automatic step_e next_step(step_e s);
    return step_e'(4'(s) + 4'd1);
  endfunction

  function automatic logic [WORD_W-1:0] align_frame(logic [WORD_W-1:0] w);
    return {w[WORD_W-1:4], 4'b0000};
  endfunction

  function automatic logic [WORD_W-1:0] word_ssp(logic [WORD_W-1:0] w);
    return {w[WORD_W-1:2], 2'b00};
  endfunction

  function automatic logic unaligned_policy(logic [WORD_W-1:0] cfg);
    return ~cfg[30];
  endfunction

  function automatic logic [2:0] limit_field(logic [WORD_W-1:0] w);
    return w[10:8];
  endfunction
endpackage

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter logic [31:0] BOOT_PTR = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_ptr,
  input  logic        rd_valid,
  input  logic [31:0] it_base,
  input  logic [31:0] spt_base,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  output logic        ld_fire,
  output step_e       ld_step,
  output logic        seq_start,
  output logic        busy,
  output logic        done
);
  phase_e      phase;
  step_e       step;
  logic [31:0] blk_ptr;

  always_comb begin
    rd_req    = (phase == PH_ISSUE);
    rd_addr   = step_addr(step, blk_ptr, it_base, spt_base);
    ld_fire   = (phase == PH_WAIT) && rd_valid;
    ld_step   = step;
    seq_start = (phase == PH_LAUNCH) || ((phase == PH_IDLE) && start);
    busy      = (phase != PH_IDLE);
    done      = (phase == PH_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_LAUNCH;
      step    <= ST_FT;
      blk_ptr <= BOOT_PTR;
    end else begin
      case (phase)
        PH_LAUNCH: begin
          step  <= ST_FT;
          phase <= PH_ISSUE;
        end
        PH_IDLE: if (start) begin
          blk_ptr <= start_ptr;
          step    <= ST_FT;
          phase   <= PH_ISSUE;
        end
        PH_ISSUE: phase <= PH_WAIT;
        PH_WAIT: if (rd_valid) begin
          if (step == ST_RCL) phase <= PH_FINISH;
          else begin
            step  <= next_step(step);
            phase <= PH_ISSUE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_regs.sv
module boot_regs
  import boot_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_fire,
  input  step_e       ld_step,
  input  logic [31:0] ld_data,
  input  logic        seq_start,
  output logic [31:0] fault_tbl_base,
  output logic [31:0] ctrl_tbl_base,
  output logic [31:0] arith_ctl,
  output logic [31:0] fault_cfg,
  output logic        unaligned_fault_en,
  output logic [31:0] intr_tbl_base,
  output logic [31:0] sysproc_base,
  output logic [31:0] sup_stack_ptr,
  output logic        trace_en,
  output logic [31:0] intr_stack_ptr,
  output logic [31:0] frame_ptr,
  output logic [31:0] stack_ptr,
  output logic [31:0] prev_frame_ptr,
  output logic [31:0] icache_ctl,
  output logic        icache_dis,
  output logic [2:0]  regcache_limit,
  output logic [31:0] ibrk0,
  output logic [31:0] ibrk1,
  output logic [31:0] dbrk0,
  output logic [31:0] dbrk1,
  output logic [31:0] brk_ctl,
  output logic [5:0]  tmr0_mode,
  output logic [5:0]  tmr1_mode,
  output logic        dcache_en,
  output logic        lmr0_en,
  output logic        lmr1_en
);
  localparam logic [31:0] FRAME_OFS = 32'(FRAME_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_tbl_base     <= '0;
      ctrl_tbl_base      <= '0;
      arith_ctl          <= '0;
      fault_cfg          <= '0;
      unaligned_fault_en <= 1'b1;
      intr_tbl_base      <= '0;
      sysproc_base       <= '0;
      sup_stack_ptr      <= '0;
      trace_en           <= 1'b0;
      intr_stack_ptr     <= '0;
      frame_ptr          <= '0;
      stack_ptr          <= '0;
      prev_frame_ptr     <= '0;
      icache_ctl         <= '0;
      icache_dis         <= 1'b0;
      regcache_limit     <= '0;
    end else if (ld_fire) begin
      case (ld_step)
        ST_FT: fault_tbl_base <= ld_data;
        ST_CT: ctrl_tbl_base  <= ld_data;
        ST_AC: arith_ctl      <= ld_data;
        ST_FC: begin
          fault_cfg          <= ld_data;
          unaligned_fault_en <= unaligned_policy(ld_data);
        end
        ST_IT:  intr_tbl_base <= ld_data;
        ST_SPT: sysproc_base  <= ld_data;
        ST_SSP: begin
          sup_stack_ptr <= word_ssp(ld_data);
          trace_en      <= ld_data[0];
        end
        ST_ISP: begin
          intr_stack_ptr <= ld_data;
          frame_ptr      <= align_frame(ld_data);
          prev_frame_ptr <= align_frame(ld_data);
          stack_ptr      <= align_frame(ld_data) + FRAME_OFS;
        end
        ST_ICC: begin
          icache_ctl <= ld_data;
          icache_dis <= ld_data[16];
        end
        ST_RCL: regcache_limit <= limit_field(ld_data);
        default: ;
      endcase
    end
  end

  // Debug, timer and region controls: only reset and a sequence start touch them.
  always_ff @(posedge clk) begin
    if (!rst_n || seq_start) begin
      ibrk0     <= '0;
      ibrk1     <= '0;
      dbrk0     <= '0;
      dbrk1     <= '0;
      brk_ctl   <= '0;
      tmr0_mode <= '0;
      tmr1_mode <= '0;
      dcache_en <= 1'b0;
      lmr0_en   <= 1'b0;
      lmr1_en   <= 1'b0;
    end
  end
endmodule

// File: rtl/boot_ram_wr.sv
module boot_ram_wr
  import boot_pkg::*;
#(
  parameter int unsigned RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  step_e             ld_step,
  input  logic [31:0]       ld_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we <= ld_fire && (ld_step == ST_NMI);
      if (ld_fire && (ld_step == ST_NMI)) ram_wdata <= ld_data;
    end
  end

  assign ram_addr = '0;
endmodule

// File: rtl/boot_blk_loader.sv
module boot_blk_loader
  import boot_pkg::*;
#(
  parameter logic [31:0] BOOT_PTR    = 32'h0000_1000,
  parameter int unsigned RAM_AW      = 10,
  parameter int unsigned FRAME_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_ptr,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       fault_tbl_base,
  output logic [31:0]       ctrl_tbl_base,
  output logic [31:0]       arith_ctl,
  output logic [31:0]       fault_cfg,
  output logic              unaligned_fault_en,
  output logic [31:0]       intr_tbl_base,
  output logic [31:0]       sysproc_base,
  output logic [31:0]       sup_stack_ptr,
  output logic              trace_en,
  output logic [31:0]       intr_stack_ptr,
  output logic [31:0]       frame_ptr,
  output logic [31:0]       stack_ptr,
  output logic [31:0]       prev_frame_ptr,
  output logic [31:0]       icache_ctl,
  output logic              icache_dis,
  output logic [2:0]        regcache_limit,
  output logic [31:0]       ibrk0,
  output logic [31:0]       ibrk1,
  output logic [31:0]       dbrk0,
  output logic [31:0]       dbrk1,
  output logic [31:0]       brk_ctl,
  output logic [5:0]        tmr0_mode,
  output logic [5:0]        tmr1_mode,
  output logic              dcache_en,
  output logic              lmr0_en,
  output logic              lmr1_en
);
  logic  ld_fire;
  step_e ld_step;
  logic  seq_start;

  boot_seq #(.BOOT_PTR(BOOT_PTR)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .rd_valid(rd_valid), .it_base(intr_tbl_base), .spt_base(sysproc_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .ld_fire(ld_fire), .ld_step(ld_step),
    .seq_start(seq_start), .busy(busy), .done(done)
  );

  boot_regs #(.FRAME_BYTES(FRAME_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_step(ld_step),
    .ld_data(rd_data), .seq_start(seq_start),
    .fault_tbl_base(fault_tbl_base), .ctrl_tbl_base(ctrl_tbl_base),
    .arith_ctl(arith_ctl), .fault_cfg(fault_cfg),
    .unaligned_fault_en(unaligned_fault_en), .intr_tbl_base(intr_tbl_base),
    .sysproc_base(sysproc_base), .sup_stack_ptr(sup_stack_ptr),
    .trace_en(trace_en), .intr_stack_ptr(intr_stack_ptr),
    .frame_ptr(frame_ptr), .stack_ptr(stack_ptr),
    .prev_frame_ptr(prev_frame_ptr), .icache_ctl(icache_ctl),
    .icache_dis(icache_dis), .regcache_limit(regcache_limit),
    .ibrk0(ibrk0), .ibrk1(ibrk1), .dbrk0(dbrk0), .dbrk1(dbrk1),
    .brk_ctl(brk_ctl), .tmr0_mode(tmr0_mode), .tmr1_mode(tmr1_mode),
    .dcache_en(dcache_en), .lmr0_en(lmr0_en), .lmr1_en(lmr1_en)
  );

  boot_ram_wr #(.RAM_AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_step(ld_step),
    .ld_data(rd_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata)
  );
endmodule

// File: rtl/boot_blk_loader_chk.sv
module boot_blk_loader_chk #(
  parameter int unsigned RAM_AW      = 10,
  parameter int unsigned FRAME_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              ld_fire,
  input logic              busy,
  input logic              done,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [31:0]       fault_cfg,
  input logic              unaligned_fault_en,
  input logic [31:0]       frame_ptr,
  input logic [31:0]       stack_ptr,
  input logic [31:0]       prev_frame_ptr,
  input logic [31:0]       sup_stack_ptr,
  input logic [31:0]       ibrk0,
  input logic [31:0]       dbrk1,
  input logic [31:0]       brk_ctl,
  input logic [5:0]        tmr0_mode,
  input logic              lmr1_en
);
  logic pending;
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else if (rd_req) pending <= 1'b1;
    else if (ld_fire) pending <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !pending); // R10
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R10
  AST_REQ_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R12
  AST_UNALIGNED_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (unaligned_fault_en == !fault_cfg[30])); // R3
  AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frame_ptr[3:0] == 4'd0 && prev_frame_ptr == frame_ptr
              && stack_ptr == frame_ptr + 32'(FRAME_BYTES))); // R6
  AST_SSP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sup_stack_ptr[1:0] == 2'b00)); // R5
  AST_DEBUG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ibrk0 == 0 && dbrk1 == 0 && brk_ctl == 0
              && tmr0_mode == 0 && !lmr1_en)); // R9
  AST_RAM_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == '0)); // R4
  AST_RAM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we); // R4
endmodule

bind boot_blk_loader boot_blk_loader_chk #(.RAM_AW(RAM_AW), .FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
  .ld_fire(ld_fire), .busy(busy), .done(done), .ram_we(ram_we),
  .ram_addr(ram_addr), .fault_cfg(fault_cfg),
  .unaligned_fault_en(unaligned_fault_en), .frame_ptr(frame_ptr),
  .stack_ptr(stack_ptr), .prev_frame_ptr(prev_frame_ptr),
  .sup_stack_ptr(sup_stack_ptr), .ibrk0(ibrk0), .dbrk1(dbrk1),
  .brk_ctl(brk_ctl), .tmr0_mode(tmr0_mode), .lmr1_en(lmr1_en)
);

// File: tb/sim_boot_blk_loader.sv
`timescale 1ns/1ps
module sim_boot_blk_loader;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, rd_valid;
  logic [31:0] start_ptr, rd_data;
  logic rd_req, ram_we, busy, done;
  logic [31:0] rd_addr, ram_wdata;
  logic [9:0] ram_addr;
  logic [31:0] fault_tbl_base, ctrl_tbl_base, arith_ctl, fault_cfg;
  logic unaligned_fault_en, trace_en, icache_dis, dcache_en, lmr0_en, lmr1_en;
  logic [31:0] intr_tbl_base, sysproc_base, sup_stack_ptr, intr_stack_ptr;
  logic [31:0] frame_ptr, stack_ptr, prev_frame_ptr, icache_ctl;
  logic [2:0] regcache_limit;
  logic [31:0] ibrk0, ibrk1, dbrk0, dbrk1, brk_ctl;
  logic [5:0] tmr0_mode, tmr1_mode;

  boot_blk_loader #(.BOOT_PTR(32'h0000_1000)) u0 (.*);

  int n_tests = 0;
  int n_fail = 0;
  int lat = 1;
  int ram_seen = 0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_nmi;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rdw(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Responder: one read at a time, data after lat cycles.
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      while (rst_n && rd_req) begin
        logic [31:0] a;
        a = rd_addr;
        repeat (lat) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = rdw(a);
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // Scoreboard monitor for read addresses and the RAM write.
  always @(negedge clk) begin
    if (rst_n && rd_req) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 R12 unexpected read", rd_addr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_addr == e, "R1 read address order", rd_addr, e);
      end
    end
    if (rst_n && ram_we) begin
      ram_seen++;
      chk(ram_addr == 10'd0, "R4 RAM address", 32'(ram_addr), 32'd0);
      chk(ram_wdata == exp_nmi, "R4 NMI vector data", ram_wdata, exp_nmi);
    end
  end

  task automatic expect_seq(input logic [31:0] p);
    logic [31:0] it, spt;
    it  = rdw(p + 32'h10);
    spt = rdw(p + 32'h14);
    exp_q.push_back(p);          exp_q.push_back(p + 32'h04);
    exp_q.push_back(p + 32'h08); exp_q.push_back(p + 32'h0C);
    exp_q.push_back(p + 32'h10); exp_q.push_back(it + 32'd996);
    exp_q.push_back(p + 32'h14); exp_q.push_back(spt + 32'h0C);
    exp_q.push_back(p + 32'h1C); exp_q.push_back(p + 32'h20);
    exp_q.push_back(p + 32'h24);
    exp_nmi = rdw(it + 32'd996);
  endtask

  task automatic check_regs(input logic [31:0] p);
    logic [31:0] fc, w, isp, fp, icc;
    chk(fault_tbl_base == rdw(p), "R2 fault table", fault_tbl_base, rdw(p));
    chk(ctrl_tbl_base == rdw(p + 4), "R2 control table", ctrl_tbl_base, rdw(p + 4));
    chk(arith_ctl == rdw(p + 8), "R2 arith ctl", arith_ctl, rdw(p + 8));
    fc = rdw(p + 12);
    chk(fault_cfg == fc, "R2 fault cfg", fault_cfg, fc);
    chk(unaligned_fault_en == (fc[30] ? 1'b0 : 1'b1), "R3 unaligned policy",
        32'(unaligned_fault_en), 32'(fc[30] ? 0 : 1));
    chk(intr_tbl_base == rdw(p + 16), "R2 intr table", intr_tbl_base, rdw(p + 16));
    chk(sysproc_base == rdw(p + 20), "R2 sysproc table", sysproc_base, rdw(p + 20));
    w = rdw(rdw(p + 20) + 12);
    chk(sup_stack_ptr == (w & 32'hFFFF_FFFC), "R5 ssp", sup_stack_ptr, w & 32'hFFFF_FFFC);
    chk(trace_en == w[0], "R5 trace", 32'(trace_en), 32'(w[0]));
    isp = rdw(p + 28);
    fp  = isp & 32'hFFFF_FFF0;
    chk(intr_stack_ptr == isp, "R6 isp", intr_stack_ptr, isp);
    chk(frame_ptr == fp, "R6 fp", frame_ptr, fp);
    chk(prev_frame_ptr == fp, "R6 pfp", prev_frame_ptr, fp);
    chk(stack_ptr == fp + 64, "R6 sp", stack_ptr, fp + 64);
    icc = rdw(p + 32);
    chk(icache_ctl == icc, "R7 icache ctl", icache_ctl, icc);
    chk(icache_dis == icc[16], "R7 icache disable", 32'(icache_dis), 32'(icc[16]));
    w = rdw(p + 36);
    chk(regcache_limit == w[10:8], "R8 limit", 32'(regcache_limit), 32'(w[10:8]));
    chk({ibrk0, ibrk1, dbrk0, dbrk1, brk_ctl} == '0, "R9 breakpoints cleared",
        ibrk0 | ibrk1 | dbrk0 | dbrk1 | brk_ctl, 32'd0);
    chk({tmr0_mode, tmr1_mode, dcache_en, lmr0_en, lmr1_en} == '0, "R9 timer/region cleared",
        32'({tmr0_mode, tmr1_mode, dcache_en, lmr0_en, lmr1_en}), 32'd0);
  endtask

  task automatic wait_done(input logic [31:0] p, input bit poke);
    int cyc = 0;
    int ram0 = ram_seen;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin
        chk(busy == 1'b1, "R12 busy mid-sequence", 32'(busy), 32'd1);
        start = 1'b1; start_ptr = 32'h0000_7000;
        @(negedge clk);
        start = 1'b0;
        cyc++;
      end
    end
    chk(done == 1'b1, "R12 done reached", 32'(done), 32'd1);
    check_regs(p);
    chk(exp_q.size() == 0, "R1 all reads issued", 32'(exp_q.size()), 32'd0);
    chk(ram_seen - ram0 == 1, "R4 one RAM write", 32'(ram_seen - ram0), 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", 32'(done), 32'd0);
    chk(busy == 1'b0, "R12 idle after done", 32'(busy), 32'd0);
  endtask

  task automatic launch(input logic [31:0] p);
    expect_seq(p);
    start = 1'b1; start_ptr = p;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 start accepted", 32'(busy), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_ptr = '0;
    // block A at 0x1000
    mem[32'h100C] = 32'h0000_0000;
    mem[32'h1010] = 32'h0000_2000;
    mem[32'h23E4] = 32'hCAFE_0001;
    mem[32'h1014] = 32'h0000_3000;
    mem[32'h300C] = 32'h0000_8003;
    mem[32'h101C] = 32'h0000_9007;
    mem[32'h1020] = 32'h0000_0004;
    mem[32'h1024] = 32'h0000_0500;
    // block B at 0x4000: edge patterns
    mem[32'h400C] = 32'h4000_0000;
    mem[32'h4010] = 32'h0000_5000;
    mem[32'h53E4] = 32'hBEEF_0002;
    mem[32'h4014] = 32'h0000_6000;
    mem[32'h600C] = 32'hFFFF_FFFF;
    mem[32'h401C] = 32'h0000_A00F;
    mem[32'h4020] = 32'h0001_0000;
    mem[32'h4024] = 32'hFFFF_F8FF;
    expect_seq(32'h1000);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R12 busy in reset", 32'(busy), 32'd1);
    chk(done == 1'b0, "R12 no done in reset", 32'(done), 32'd0);
    chk(rd_req == 1'b0, "R10 no read in reset", 32'(rd_req), 32'd0);
    chk(ram_we == 1'b0, "R4 no write in reset", 32'(ram_we), 32'd0);
    rst_n = 1'b1;
    wait_done(32'h1000, 1'b0);            // R11 power-on run
    lat = 2;
    launch(32'h4000);
    wait_done(32'h4000, 1'b0);
    lat = 3;
    launch(32'h1000);
    wait_done(32'h1000, 1'b1);            // R12 start while busy ignored
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R12 ignored start not latched", 32'(busy), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule